// File: doc/BRIEF.md
# PCIe Outbound Address Translation Windows

This block maps addresses issued by a local bus master onto a 64-bit PCIe memory space. A local region, starting at a fixed base, is cut into a parameterised number of equally sized windows (32 by default). Each window carries its own 64-bit remote base and a valid flag. A local request is resolved in one clock cycle into either a translated remote address or a miss.

Software programs the block through a simple word-wide register port. The port holds a command word whose bit 1 switches translation on, a 3-bit size index that sets the window size to 1 MB shifted left by the index, and one low/high pair of words per window. Bit 0 of a low word marks its window valid. The bits of the low word above the window size, together with the high word, form the remote base. The offset of the request inside its window is added to that base.

Top module: `pcie_ob_xlate`

## Requirements
- R1: While reset is asserted and after it is released, respValid and respMiss are low, and every register reads back as zero.
- R2: A word written to the command offset (0x004), to a window low offset (0x200 + 8·n) or to a window high offset (0x204 + 8·n) reads back unchanged. The size offset (0x030) stores bits 2:0 and reads back zero in bits 31:3. Address bits 1:0 are ignored.
- R3: A read of any offset that is not a register returns zero. A write to such an offset changes no register.
- R4: A request sampled with reqValid high produces respValid high on the next cycle only. respValid is low in every cycle that does not follow a request.
- R5: A request misses whenever command bit 1 is clear, whatever the other command bits hold.
- R6: For an enabled, valid window, with off = reqAddr − REGION_BASE, sh = 20 + size index and mask = 2^sh − 1, the window index is off >> sh. respAddr is {high word, low word & ~mask} + (off & mask).
- R7: A request whose selected window has bit 0 of its low word clear is a miss.
- R8: A request below REGION_BASE, or whose window index is NUM_WIN or more, is a miss.
- R9: A size index write takes effect for requests in later cycles. A request presented in the same cycle as the write uses the old size.
- R10: On a miss respAddr is zero, and respMiss is never high without respValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 12 | Register byte offset, used for reads and writes |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr, combinational |
| reqValid | input | 1 | Local request present |
| reqAddr | input | 32 | Local request address |
| respValid | output | 1 | Result of the request from the previous cycle |
| respMiss | output | 1 | That request had no valid translation |
| respAddr | output | 64 | Translated remote address, zero on a miss |

## Verification
The hardest cases to reach are the window edges at every size index. These are the first and last byte of each window, the first address past the last window, and the address just below the region base. The size index moves every one of them, so only a sweep over all eight indices covers them. The bench gives the test configuration eight windows, one of them invalid, and walks all size indices across every window and two indices beyond. It computes each expected address arithmetically. A separate cycle writes a new size index in the same edge as a request, to show the request still sees the old size.

// File: rtl/obx_pkg.sv
package obx_pkg;
  localparam int DATA_W  = 32;
  localparam int LADDR_W = 32;
  localparam int RADDR_W = 64;
  localparam int SIZE_W  = 3;
  localparam int MB_SHIFT = 20;
  localparam int WIDX_MAX_W = 6;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CMD,
    RD_SIZE,
    RD_LO,
    RD_HI
  } obxRdSel_e;

  typedef struct packed {
    logic                  cmdWr;
    logic                  sizeWr;
    logic                  loWr;
    logic                  hiWr;
    logic [WIDX_MAX_W-1:0] winIdx;
    obxRdSel_e             rdSel;
  } obxStrobe_t;
endpackage

// File: rtl/obx_ctrl.sv
module obx_ctrl
  import obx_pkg::*;
#(
  parameter int NUM_WIN  = 32,
  parameter int REG_AW   = 12,
  parameter int CMD_OFS  = 'h004,
  parameter int SIZE_OFS = 'h030,
  parameter int WIN_OFS  = 'h200
) (
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  output obxStrobe_t        strobes
);
  localparam int WIN_END = WIN_OFS + 8 * NUM_WIN;

  logic [REG_AW-1:0] wordAddr;
  logic [REG_AW-1:0] winRel;
  logic              inWin;

  assign wordAddr = {regAddr[REG_AW-1:2], 2'b00};
  assign inWin    = (int'(wordAddr) >= WIN_OFS) && (int'(wordAddr) < WIN_END);
  assign winRel   = wordAddr - REG_AW'(WIN_OFS);

  always_comb begin
    strobes        = '0;
    strobes.rdSel  = RD_NONE;
    strobes.winIdx = winRel[WIDX_MAX_W+2:3];
    if (int'(wordAddr) == CMD_OFS) begin
      strobes.rdSel = RD_CMD;
      strobes.cmdWr = regWrEn;
    end else if (int'(wordAddr) == SIZE_OFS) begin
      strobes.rdSel  = RD_SIZE;
      strobes.sizeWr = regWrEn;
    end else if (inWin) begin
      if (wordAddr[2]) begin
        strobes.rdSel = RD_HI;
        strobes.hiWr  = regWrEn;
      end else begin
        strobes.rdSel = RD_LO;
        strobes.loWr  = regWrEn;
      end
    end
  end
endmodule

// File: rtl/obx_winfile.sv
module obx_winfile
  import obx_pkg::*;
#(
  parameter int NUM_WIN = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  obxStrobe_t                     strobes,
  input  logic [DATA_W-1:0]              wrData,
  output logic [NUM_WIN-1:0][DATA_W-1:0] loArr,
  output logic [NUM_WIN-1:0][DATA_W-1:0] hiArr
);
  genvar w;
  generate
    for (w = 0; w < NUM_WIN; w++) begin : gWin
      logic selThis;
      assign selThis = (int'(strobes.winIdx) == w);

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          loArr[w] <= '0;
          hiArr[w] <= '0;
        end else begin
          if (strobes.loWr && selThis) loArr[w] <= wrData;
          if (strobes.hiWr && selThis) hiArr[w] <= wrData;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/obx_xlate.sv
module obx_xlate
  import obx_pkg::*;
#(
  parameter int              NUM_WIN     = 32,
  parameter logic [LADDR_W-1:0] REGION_BASE = 32'h0
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  obxStrobe_t                     strobes,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [NUM_WIN-1:0][DATA_W-1:0] loArr,
  input  logic [NUM_WIN-1:0][DATA_W-1:0] hiArr,
  output logic [DATA_W-1:0]              rdData,
  input  logic                           reqValid,
  input  logic [LADDR_W-1:0]             reqAddr,
  output logic                           respValid,
  output logic                           respMiss,
  output logic [RADDR_W-1:0]             respAddr
);
  localparam int WIDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int EN_BIT = 1;

  logic [DATA_W-1:0]  cmdReg;
  logic [SIZE_W-1:0]  sizeReg;

  logic [LADDR_W-1:0] offs;
  logic               belowBase;
  logic [5:0]         shAmt;
  logic [LADDR_W-1:0] idxFull;
  logic               idxOk;
  logic [WIDX_W-1:0]  winSel;
  logic [LADDR_W-1:0] winMask;
  logic [DATA_W-1:0]  selLo;
  logic [DATA_W-1:0]  selHi;
  logic [RADDR_W-1:0] remoteBase;
  logic [RADDR_W-1:0] xlated;
  logic               hit;

  // control words
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg  <= '0;
      sizeReg <= '0;
    end else begin
      if (strobes.cmdWr)  cmdReg  <= wrData;
      if (strobes.sizeWr) sizeReg <= wrData[SIZE_W-1:0];
    end
  end

  // read mux
  always_comb begin
    rdData = '0;
    case (strobes.rdSel)
      RD_CMD:  rdData = cmdReg;
      RD_SIZE: rdData = DATA_W'(sizeReg);
      RD_LO:   rdData = loArr[strobes.winIdx[WIDX_W-1:0]];
      RD_HI:   rdData = hiArr[strobes.winIdx[WIDX_W-1:0]];
      default: rdData = '0;
    endcase
  end

  // lookup
  assign belowBase = reqAddr < REGION_BASE;
  assign offs      = reqAddr - REGION_BASE;
  assign shAmt     = 6'(MB_SHIFT) + 6'(sizeReg);
  assign idxFull   = offs >> shAmt;
  assign idxOk     = idxFull < LADDR_W'(NUM_WIN);
  assign winSel    = idxFull[WIDX_W-1:0];
  assign winMask   = (LADDR_W'(1) << shAmt) - LADDR_W'(1);
  assign selLo     = loArr[winSel];
  assign selHi     = hiArr[winSel];
  assign remoteBase = {selHi, selLo & ~winMask};
  assign xlated     = remoteBase + RADDR_W'(offs & winMask);
  assign hit        = cmdReg[EN_BIT] && !belowBase && idxOk && selLo[0];

  // result register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respMiss  <= 1'b0;
      respAddr  <= '0;
    end else begin
      respValid <= reqValid;
      respMiss  <= reqValid && !hit;
      respAddr  <= (reqValid && hit) ? xlated : '0;
    end
  end
endmodule

// File: rtl/pcie_ob_xlate.sv
module pcie_ob_xlate
  import obx_pkg::*;
#(
  parameter int                 NUM_WIN     = 32,
  parameter logic [LADDR_W-1:0] REGION_BASE = 32'h0,
  parameter int                 REG_AW      = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               reqValid,
  input  logic [LADDR_W-1:0] reqAddr,
  output logic               respValid,
  output logic               respMiss,
  output logic [RADDR_W-1:0] respAddr
);
  obxStrobe_t                     strobes;
  logic [NUM_WIN-1:0][DATA_W-1:0] loArr;
  logic [NUM_WIN-1:0][DATA_W-1:0] hiArr;

  obx_ctrl #(.NUM_WIN(NUM_WIN), .REG_AW(REG_AW)) u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strobes (strobes)
  );

  obx_winfile #(.NUM_WIN(NUM_WIN)) u_win (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (regWrData),
    .loArr   (loArr),
    .hiArr   (hiArr)
  );

  obx_xlate #(.NUM_WIN(NUM_WIN), .REGION_BASE(REGION_BASE)) u_xlate (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .wrData    (regWrData),
    .loArr     (loArr),
    .hiArr     (hiArr),
    .rdData    (regRdData),
    .reqValid  (reqValid),
    .reqAddr   (reqAddr),
    .respValid (respValid),
    .respMiss  (respMiss),
    .respAddr  (respAddr)
  );
endmodule

// File: rtl/obx_chk.sv
module obx_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [11:0] regAddr,
  input logic [31:0] regWrData,
  input logic [31:0] regRdData,
  input logic        reqValid,
  input logic [31:0] reqAddr,
  input logic        respValid,
  input logic        respMiss,
  input logic [63:0] respAddr
);
  logic enShadow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enShadow <= 1'b0;
    else if (regWrEn && regAddr[11:2] == 10'h001) enShadow <= regWrData[1];
  end

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!respValid && !respMiss);
    end
  end

  // R4
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid);

  // R4
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid);

  // R5
  disabled_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !enShadow) |=> respMiss);

  // R10
  miss_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    respMiss |-> (respValid && respAddr == 64'h0));

  // R2
  size_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[11:2] == 10'h00C) |-> (regRdData[31:3] == 29'h0));
endmodule

bind pcie_ob_xlate obx_chk u_chk (.*);

// File: tb/pcie_ob_xlate_bench.sv
`timescale 1ns/1ps
module pcie_ob_xlate_bench;
  localparam int          NW    = 8;
  localparam logic [31:0] RBASE = 32'h1000_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        respValid, respMiss;
  logic [63:0] respAddr;

  int nTests = 0;
  int nFail = 0;

  logic [31:0] bLo [NW];
  logic [31:0] bHi [NW];
  logic [2:0]  bSz;
  logic        bEn;

  always #5 clk = ~clk;

  pcie_ob_xlate #(.NUM_WIN(NW), .REGION_BASE(RBASE)) u_pcie_ob_xlate (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    chk(regRdData == exp, tag, 64'(regRdData), 64'(exp));
  endtask

  function automatic void model(input logic [31:0] a, output bit miss, output logic [63:0] ra);
    logic [31:0] off, msk, idx;
    int sh;
    sh  = 20 + int'(bSz);
    off = a - RBASE;
    msk = (32'h1 << sh) - 32'h1;
    idx = off >> sh;
    miss = !bEn || (a < RBASE) || (idx >= NW);
    if (!miss) miss = !bLo[idx][0];
    ra = miss ? 64'h0 : ({bHi[idx], bLo[idx] & ~msk} + 64'(off & msk));
  endfunction

  task automatic req(input logic [31:0] a, input string tag);
    bit          em;
    logic [63:0] ea;
    model(a, em, ea);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    chk(respValid == 1'b1, {tag, " R4 valid"}, 64'(respValid), 64'h1);
    chk(respMiss == em, {tag, " miss"}, 64'(respMiss), 64'(em));
    chk(respAddr == ea, {tag, " addr"}, respAddr, ea);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(respValid == 0 && respMiss == 0, "R1 outputs in reset", 64'(respValid), 0);
    rstN = 1'b1;
    rdChk(12'h004, 32'h0, "R1 cmd reset");
    rdChk(12'h030, 32'h0, "R1 size reset");
    rdChk(12'h200, 32'h0, "R1 lo0 reset");
    @(negedge clk);
    chk(respValid == 0, "R1 idle valid", 64'(respValid), 0);

    // R2 readback
    wr(12'h004, 32'hDEAD_BEEF);
    rdChk(12'h004, 32'hDEAD_BEEF, "R2 cmd");
    rdChk(12'h007, 32'hDEAD_BEEF, "R2 cmd low bits ignored");
    wr(12'h030, 32'hFFFF_FFFD);
    rdChk(12'h030, 32'h5, "R2 size");
    // R3 unmapped
    wr(12'h100, 32'h1234_5678);
    wr(12'h200 + 12'(8 * NW), 32'h5555_AAAA);
    rdChk(12'h100, 32'h0, "R3 unmapped read");
    rdChk(12'h200 + 12'(8 * NW), 32'h0, "R3 past windows");
    rdChk(12'h004, 32'hDEAD_BEEF, "R3 cmd untouched");
    rdChk(12'h030, 32'h5, "R3 size untouched");
    rdChk(12'h200, 32'h0, "R3 lo0 untouched");

    // program windows
    for (int n = 0; n < NW; n++) begin
      bLo[n] = (32'h8000_0000 ^ (32'(n) << 27)) | 32'h0350_0000 | ((n == 5) ? 32'h0 : 32'h1);
      bHi[n] = 32'h0000_1000 + 32'(n * 3);
      wr(12'h200 + 12'(8 * n), bLo[n]);
      wr(12'h204 + 12'(8 * n), bHi[n]);
    end
    for (int n = 0; n < NW; n++) begin
      rdChk(12'h200 + 12'(8 * n), bLo[n], "R2 lo");
      rdChk(12'h204 + 12'(8 * n), bHi[n], "R2 hi");
    end

    // R5: all command bits but bit 1
    bSz = 3'd0; bEn = 1'b0;
    wr(12'h030, 32'h0);
    wr(12'h004, 32'hFFFF_FFFD);
    req(RBASE, "R5 disabled");
    req(RBASE + 32'h0010_0000, "R5 disabled w1");
    wr(12'h004, 32'h0000_0002); bEn = 1'b1;

    // R6 R7 R8 sweep over sizes, windows and offsets
    for (int s = 0; s < 8; s++) begin
      logic [31:0] msk;
      bSz = 3'(s);
      wr(12'h030, 32'(s));
      msk = (32'h1 << (20 + s)) - 32'h1;
      req(RBASE - 32'h1, "R8 below base");
      for (int w = 0; w < NW + 2; w++) begin
        logic [31:0] wb;
        wb = RBASE + (32'(w) << (20 + s));
        req(wb, "R6 R7 R8 window start");
        req(wb + msk, "R6 R7 R8 window end");
        req(wb + (32'h00A5_A5A5 & msk), "R6 window mid");
      end
    end

    // R9: size write and request in the same cycle use the old size
    bSz = 3'd0;
    wr(12'h030, 32'h0);
    begin
      bit          em;
      logic [63:0] ea;
      model(RBASE + 32'h0030_0000, em, ea);
      @(negedge clk);
      regWrEn = 1'b1; regAddr = 12'h030; regWrData = 32'h2;
      reqValid = 1'b1; reqAddr = RBASE + 32'h0030_0000;
      @(negedge clk);
      regWrEn = 1'b0; reqValid = 1'b0;
      chk(respAddr == ea && respMiss == em, "R9 old size", respAddr, ea);
      bSz = 3'd2;
      req(RBASE + 32'h0030_0000, "R9 new size");
    end

    @(negedge clk);
    chk(respValid == 0, "R4 single cycle", 64'(respValid), 0);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule